// File: doc/BRIEF.md
# Interlaced raster timing generator

This block keeps track of where the electron beam is on an interlaced 50 Hz style display. A horizontal counter counts pixels of a 16 MHz pixel clock, but it advances only on a tick enable that stands for eight pixels, so it steps by 8 on every tick. When the counter reaches the end of the line, it wraps and the line counter moves on. The last line index alternates between two values. A field flag records which field is being drawn, and it toggles each time the line counter wraps.

From the position it drives the horizontal and vertical sync levels. It also produces two interrupt strobes. The periodic strobe fires once per field. The end-of-display strobe fires when the last visible line of the current mode (graphics or text) reaches the start of horizontal sync. Interlace comes from moving the vertical sync edges and the periodic strobe to the half-line point in one of the two fields. All break points are parameters. Sync levels and strobes are registered, so each one changes on the same clock edge as the counters that show the new position.

Top module: `rtg_top`

## Requirements
- R1: Each clock with `tick` high advances `hCount` by 8. When the result would equal H_TOTAL (default 1024), `hCount` becomes 0 and `vCount` increments.
- R2: A clock with `tick` low changes none of `hCount`, `vCount` and `field`.
- R3: The last line index is V_LAST_ODD (312) while `field` is 1 and V_LAST_EVEN (311) while `field` is 0. Leaving the last line sets `vCount` to 0 and inverts `field`.
- R4: With `field` 1, `vSync` rises when the position reaches line VS_START (274) at H_HALF (512). It falls when the position reaches line VS_END+1 (277) at 0.
- R5: With `field` 0, `vSync` rises when the position reaches line VS_START at 0. It falls when the position reaches line VS_END (276) at H_HALF.
- R6: `hSync` rises when `hCount` reaches HS_START (768) and falls when it reaches HS_END (832).
- R7: `periodicIrq` pulses when the position reaches line V_PERIODIC (100). The pulse comes at `hCount` 0 when `field` is 0 and at H_HALF when `field` is 1.
- R8: `dispEndIrq` pulses when `hCount` reaches HS_START on line V_LAST_GFX (255) with `textMode` 0, or on line V_LAST_TXT (249) with `textMode` 1. It does not pulse on the line that belongs to the other mode.
- R9: Each strobe is high for exactly one clock. Neither strobe is ever high in the clock after a clock with `tick` low.
- R10: After synchronous reset `hCount` and `vCount` are 0, `field` is 1, and both syncs and both strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Advance by one 8-pixel step |
| textMode | input | 1 | Selects the text-mode last display line |
| hCount | output | H_W | Horizontal position in pixels |
| vCount | output | V_W | Line number within the field |
| field | output | 1 | Field flag, 1 after reset |
| hSync | output | 1 | Horizontal sync level |
| vSync | output | 1 | Vertical sync level |
| periodicIrq | output | 1 | Once-per-field strobe |
| dispEndIrq | output | 1 | End-of-display strobe |

## Verification
The hardest case to reach is the field 0 behaviour: the early vertical sync rise, the half-line sync fall and the periodic strobe at line start. These occur only after a complete first field of about forty thousand ticks. The bench keeps a running tick count and, for each target position (field, line, pixel), converts it to an absolute tick number. It then holds `tick` high for exactly the ticks needed to get there. This lets it land one step before and on each edge in both fields. The same approach is used to switch `textMode` part way through so that the end-of-display line of each mode is checked.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  // Strobes the control issues to the counter datapath each clock.
  typedef struct packed {
    logic advance;    // move one 8-pixel step
    logic lineWrap;   // this step ends the line
    logic frameWrap;  // this step ends the field
  } rasterStep_t;
endpackage

// File: rtl/rtg_ctrl.sv
module rtg_ctrl #(
  parameter int H_TOTAL     = 1024,
  parameter int V_LAST_ODD  = 312,
  parameter int V_LAST_EVEN = 311,
  parameter int H_W         = $clog2(H_TOTAL),
  parameter int V_W         = $clog2(V_LAST_ODD + 2)
) (
  input  logic                     tick,
  input  logic [H_W-1:0]           hCount,
  input  logic [V_W-1:0]           vCount,
  input  logic                     field,
  output rtg_pkg::rasterStep_t     step
);
  localparam logic [H_W-1:0] H_LAST = H_W'(H_TOTAL - 8);

  logic atLineEnd;
  logic atFieldEnd;

  always_comb begin
    atLineEnd  = (hCount == H_LAST);
    atFieldEnd = field ? (vCount == V_W'(V_LAST_ODD)) : (vCount == V_W'(V_LAST_EVEN));
    step.advance   = tick;
    step.lineWrap  = tick && atLineEnd;
    step.frameWrap = tick && atLineEnd && atFieldEnd;
  end
endmodule

// File: rtl/rtg_datapath.sv
module rtg_datapath #(
  parameter int H_TOTAL    = 1024,
  parameter int V_LAST_ODD = 312,
  parameter int H_W        = $clog2(H_TOTAL),
  parameter int V_W        = $clog2(V_LAST_ODD + 2)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  rtg_pkg::rasterStep_t step,
  output logic [H_W-1:0]       hCount,
  output logic [V_W-1:0]       vCount,
  output logic                 field,
  output logic [H_W-1:0]       nextH,
  output logic [V_W-1:0]       nextV,
  output logic                 nextField
);
  always_comb begin
    nextH     = hCount;
    nextV     = vCount;
    nextField = field;
    if (step.advance) begin
      nextH = step.lineWrap ? '0 : hCount + H_W'(8);
      if (step.frameWrap) begin
        nextV     = '0;
        nextField = ~field;
      end else if (step.lineWrap) begin
        nextV = vCount + V_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hCount <= '0;
      vCount <= '0;
      field  <= 1'b1;
    end else begin
      hCount <= nextH;
      vCount <= nextV;
      field  <= nextField;
    end
  end
endmodule

// File: rtl/rtg_events.sv
module rtg_events #(
  parameter int H_HALF      = 512,
  parameter int HS_START    = 768,
  parameter int HS_END      = 832,
  parameter int VS_START    = 274,
  parameter int VS_END      = 276,
  parameter int V_PERIODIC  = 100,
  parameter int V_LAST_GFX  = 255,
  parameter int V_LAST_TXT  = 249,
  parameter int H_W         = 10,
  parameter int V_W         = 9
) (
  input  logic                 clk,
  input  logic                 rst,
  input  rtg_pkg::rasterStep_t step,
  input  logic                 textMode,
  input  logic [H_W-1:0]       nextH,
  input  logic [V_W-1:0]       nextV,
  input  logic                 nextField,
  output logic                 hSync,
  output logic                 vSync,
  output logic                 periodicIrq,
  output logic                 dispEndIrq
);
  logic atLineStart, atHalf, atHsStart, atHsEnd;
  logic onVsStart, onVsEnd, onVsAfter, onPeriodic, onDispEnd;

  always_comb begin
    atLineStart = (nextH == '0);
    atHalf      = (nextH == H_W'(H_HALF));
    atHsStart   = (nextH == H_W'(HS_START));
    atHsEnd     = (nextH == H_W'(HS_END));
    onVsStart   = (nextV == V_W'(VS_START));
    onVsEnd     = (nextV == V_W'(VS_END));
    onVsAfter   = (nextV == V_W'(VS_END + 1));
    onPeriodic  = (nextV == V_W'(V_PERIODIC));
    onDispEnd   = textMode ? (nextV == V_W'(V_LAST_TXT)) : (nextV == V_W'(V_LAST_GFX));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hSync       <= 1'b0;
      vSync       <= 1'b0;
      periodicIrq <= 1'b0;
      dispEndIrq  <= 1'b0;
    end else begin
      periodicIrq <= step.advance && onPeriodic && (nextField ? atHalf : atLineStart);
      dispEndIrq  <= step.advance && onDispEnd && atHsStart;
      if (step.advance) begin
        if (atHsStart)    hSync <= 1'b1;
        else if (atHsEnd) hSync <= 1'b0;
        if (!nextField) begin
          if (atLineStart && onVsStart) vSync <= 1'b1;
          else if (atHalf && onVsEnd)   vSync <= 1'b0;
        end else begin
          if (atHalf && onVsStart)           vSync <= 1'b1;
          else if (atLineStart && onVsAfter) vSync <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/rtg_top.sv
module rtg_top #(
  parameter int H_TOTAL     = 1024,
  parameter int H_HALF      = 512,
  parameter int HS_START    = 768,
  parameter int HS_END      = 832,
  parameter int V_LAST_ODD  = 312,
  parameter int V_LAST_EVEN = 311,
  parameter int VS_START    = 274,
  parameter int VS_END      = 276,
  parameter int V_PERIODIC  = 100,
  parameter int V_LAST_GFX  = 255,
  parameter int V_LAST_TXT  = 249,
  localparam int H_W        = $clog2(H_TOTAL),
  localparam int V_W        = $clog2(V_LAST_ODD + 2)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tick,
  input  logic           textMode,
  output logic [H_W-1:0] hCount,
  output logic [V_W-1:0] vCount,
  output logic           field,
  output logic           hSync,
  output logic           vSync,
  output logic           periodicIrq,
  output logic           dispEndIrq
);
  if ((H_TOTAL % 8) != 0 || (H_HALF % 8) != 0 || (HS_START % 8) != 0 || (HS_END % 8) != 0)
  begin : g_badHoriz
    $error("rtg_top: horizontal parameters must be multiples of 8");
  end

  rtg_pkg::rasterStep_t step;
  logic [H_W-1:0] nextH;
  logic [V_W-1:0] nextV;
  logic           nextField;

  rtg_ctrl #(.H_TOTAL(H_TOTAL), .V_LAST_ODD(V_LAST_ODD), .V_LAST_EVEN(V_LAST_EVEN),
             .H_W(H_W), .V_W(V_W)) u_ctrl (
    .tick(tick), .hCount(hCount), .vCount(vCount), .field(field), .step(step));

  rtg_datapath #(.H_TOTAL(H_TOTAL), .V_LAST_ODD(V_LAST_ODD), .H_W(H_W), .V_W(V_W)) u_dp (
    .clk(clk), .rst(rst), .step(step), .hCount(hCount), .vCount(vCount), .field(field),
    .nextH(nextH), .nextV(nextV), .nextField(nextField));

  rtg_events #(.H_HALF(H_HALF), .HS_START(HS_START), .HS_END(HS_END), .VS_START(VS_START),
               .VS_END(VS_END), .V_PERIODIC(V_PERIODIC), .V_LAST_GFX(V_LAST_GFX),
               .V_LAST_TXT(V_LAST_TXT), .H_W(H_W), .V_W(V_W)) u_ev (
    .clk(clk), .rst(rst), .step(step), .textMode(textMode), .nextH(nextH), .nextV(nextV),
    .nextField(nextField), .hSync(hSync), .vSync(vSync), .periodicIrq(periodicIrq),
    .dispEndIrq(dispEndIrq));
endmodule

// File: rtl/rtg_checker.sv
module rtg_checker #(
  parameter int H_TOTAL     = 1024,
  parameter int HS_START    = 768,
  parameter int V_LAST_ODD  = 312,
  parameter int V_LAST_EVEN = 311,
  parameter int H_W         = 10,
  parameter int V_W         = 9
) (
  input logic           clk,
  input logic           rst,
  input logic           tick,
  input logic [H_W-1:0] hCount,
  input logic [V_W-1:0] vCount,
  input logic           field,
  input logic           hSync,
  input logic           periodicIrq,
  input logic           dispEndIrq
);
  localparam logic [H_W-1:0] H_LAST = H_W'(H_TOTAL - 8);

  p_hstep_r1: assert property (@(posedge clk) disable iff (rst)
    (tick && hCount != H_LAST) |=> hCount == $past(hCount) + H_W'(8));
  p_hwrap_r1: assert property (@(posedge clk) disable iff (rst)
    (tick && hCount == H_LAST) |=> hCount == '0);
  p_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !tick |=> ($stable(hCount) && $stable(vCount) && $stable(field)));
  p_fieldflip_r3: assert property (@(posedge clk) disable iff (rst)
    !$stable(field) |-> (vCount == '0 && hCount == '0));
  p_vlimit_r3: assert property (@(posedge clk) disable iff (rst)
    vCount <= (field ? V_W'(V_LAST_ODD) : V_W'(V_LAST_EVEN)));
  p_hsrise_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(hSync) |-> hCount == H_W'(HS_START));
  p_perpulse_r9: assert property (@(posedge clk) disable iff (rst)
    periodicIrq |=> !periodicIrq);
  p_endpulse_r9: assert property (@(posedge clk) disable iff (rst)
    dispEndIrq |=> !dispEndIrq);
  p_notick_r9: assert property (@(posedge clk) disable iff (rst)
    !tick |=> (!periodicIrq && !dispEndIrq));
endmodule

bind rtg_top rtg_checker #(.H_TOTAL(H_TOTAL), .HS_START(HS_START), .V_LAST_ODD(V_LAST_ODD),
  .V_LAST_EVEN(V_LAST_EVEN), .H_W(H_W), .V_W(V_W)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .hCount(hCount), .vCount(vCount), .field(field),
  .hSync(hSync), .periodicIrq(periodicIrq), .dispEndIrq(dispEndIrq));

// File: tb/sim_rtg_top.sv
module sim_rtg_top;
  localparam int H    = 1024;
  localparam int TPL  = H / 8;
  localparam int F0   = (312 + 1) * TPL;
  localparam int F1   = F0 + (311 + 1) * TPL;
  localparam int HALF = 512, HSS = 768, HSE = 832;
  localparam int VSS = 274, VSE = 276, VP = 100, VG = 255, VT = 249;

  logic clk = 1'b0, rst = 1'b1, tick = 1'b0, textMode = 1'b0;
  logic [9:0] hCount;
  logic [8:0] vCount;
  logic field, hSync, vSync, periodicIrq, dispEndIrq;
  int checks = 0, fails = 0, n = 0;

  always #5 clk = ~clk;

  rtg_top u0 (.clk(clk), .rst(rst), .tick(tick), .textMode(textMode), .hCount(hCount),
    .vCount(vCount), .field(field), .hSync(hSync), .vSync(vSync),
    .periodicIrq(periodicIrq), .dispEndIrq(dispEndIrq));

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int at(input int fr, input int v, input int h);
    return (fr == 0 ? 0 : F0) + v * TPL + h / 8;
  endfunction

  task automatic tickTo(input int target);
    int k = target - n;
    if (k <= 0) return;
    @(negedge clk); tick = 1'b1;
    repeat (k) @(negedge clk);
    tick = 1'b0;
    n = target;
  endtask

  task automatic idleCycle();
    @(negedge clk);
  endtask

  task automatic testReset();
    check("R10 hCount", hCount, 0);
    check("R10 vCount", vCount, 0);
    check("R10 field", field, 1);
    check("R10 syncs", {hSync, vSync}, 0);
    check("R10 strobes", {periodicIrq, dispEndIrq}, 0);
  endtask

  task automatic testIdle();
    repeat (3) idleCycle();
    check("R2 hCount idle", hCount, 0);
    check("R2 vCount idle", vCount, 0);
    check("R2 field idle", field, 1);
  endtask

  task automatic testHorizontal();
    tickTo(at(0, 0, 8));    check("R1 first step", hCount, 8);
    tickTo(at(0, 0, 760));  check("R6 before start", hSync, 0);
    tickTo(at(0, 0, HSS));  check("R6 rise", hSync, 1);
    check("R8 other line", dispEndIrq, 0);
    tickTo(at(0, 0, 824));  check("R6 still high", hSync, 1);
    tickTo(at(0, 0, HSE));  check("R6 fall", hSync, 0);
    tickTo(at(0, 0, 1016)); check("R1 last step h", hCount, 1016);
    check("R1 last step v", vCount, 0);
    tickTo(at(0, 1, 0));    check("R1 wrap h", hCount, 0);
    check("R1 wrap v", vCount, 1);
  endtask

  task automatic testPeriodicOdd();
    tickTo(at(0, VP, 0));   check("R7 odd not at 0", periodicIrq, 0);
    tickTo(at(0, VP, 504)); check("R7 odd before half", periodicIrq, 0);
    tickTo(at(0, VP, HALF)); check("R7 odd at half", periodicIrq, 1);
    idleCycle();            check("R9 no tick clears", periodicIrq, 0);
    check("R2 hold after idle", hCount, HALF);
    tickTo(at(0, VP, HALF + 8)); check("R9 one clock wide", periodicIrq, 0);
  endtask

  task automatic testDispEndGfx();
    textMode = 1'b0;
    tickTo(at(0, VT, HSS)); check("R8 gfx on text line", dispEndIrq, 0);
    tickTo(at(0, VG, HSS)); check("R8 gfx line", dispEndIrq, 1);
    tickTo(at(0, VG, HSS + 8)); check("R9 end strobe drops", dispEndIrq, 0);
  endtask

  task automatic testVsyncOdd();
    tickTo(at(0, VSS, 0));     check("R4 no rise at 0", vSync, 0);
    tickTo(at(0, VSS, 504));   check("R4 before half", vSync, 0);
    tickTo(at(0, VSS, HALF));  check("R4 rise at half", vSync, 1);
    tickTo(at(0, VSE, HALF));  check("R4 held at end half", vSync, 1);
    tickTo(at(0, VSE, 1016));  check("R4 held to line end", vSync, 1);
    tickTo(at(0, VSE + 1, 0)); check("R4 fall next line", vSync, 0);
  endtask

  task automatic testWrapOdd();
    tickTo(at(0, 312, 1016)); check("R3 odd last line", vCount, 312);
    check("R3 odd field", field, 1);
    tickTo(F0);               check("R3 odd wrap v", vCount, 0);
    check("R3 odd wrap h", hCount, 0);
    check("R3 field toggles", field, 0);
  endtask

  task automatic testEven();
    tickTo(at(1, VP, 0));     check("R7 even at 0", periodicIrq, 1);
    tickTo(at(1, VP, 8));     check("R9 even pulse ends", periodicIrq, 0);
    tickTo(at(1, VP, HALF));  check("R7 even not at half", periodicIrq, 0);
    textMode = 1'b1;
    tickTo(at(1, VT, HSS));   check("R8 text line", dispEndIrq, 1);
    tickTo(at(1, VG, HSS));   check("R8 text on gfx line", dispEndIrq, 0);
    tickTo(at(1, VSS - 1, 1016)); check("R5 before rise", vSync, 0);
    tickTo(at(1, VSS, 0));    check("R5 rise at 0", vSync, 1);
    tickTo(at(1, VSE, 504));  check("R5 held", vSync, 1);
    tickTo(at(1, VSE, HALF)); check("R5 fall at half", vSync, 0);
  endtask

  task automatic testWrapEven();
    tickTo(at(1, 311, 1016)); check("R3 even last line", vCount, 311);
    check("R3 even field", field, 0);
    tickTo(F1);               check("R3 even wrap v", vCount, 0);
    check("R3 field back", field, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    testReset();
    testIdle();
    testHorizontal();
    testPeriodicOdd();
    testDispEndGfx();
    testVsyncOdd();
    testWrapOdd();
    testEven();
    testWrapEven();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", n, F1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule